// File: doc/BRIEF.md
# MESI Snooping Line State Controller

This block keeps the coherence state of every line in a small direct-mapped, write-back cache that shares a bus with other caches and uses write-invalidate. Each line stores a tag and one of four states. Modified means the copy is dirty, memory is stale, and no other cache holds the line. Exclusive means the copy is clean and no other cache holds it. Shared means the copy is clean and other caches may also hold it. Invalid means the line holds nothing usable. Processor reads and writes are served at once when the state allows it. Otherwise the controller requests the bus, waits for the grant and the transfer, and then installs the new state.

Transactions that other caches place on the bus arrive on a snoop port. The controller answers in the same cycle. It can flush dirty data, supply clean exclusive data and raise a shared-sense output. The state change takes effect at the next clock edge. The requester reads the shared-sense line at the end of its own read miss. From that it installs the line as Shared or as Exclusive. A write from Exclusive then goes to Modified without using the bus.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After the asynchronous reset every line is Invalid. bus_req_o and cpu_ready_o are low, and a snoop to any line gives no flush, supply or shared response.
- R2: A processor read that misses issues bus op 1 (read) for the requested line. When bus_done_i arrives, the line is installed as Shared if bus_shared_i is high, and as Exclusive if it is low.
- R3: A processor write to an Invalid or Shared line issues bus op 2 (read-exclusive) and installs the line as Modified.
- R4: A processor write to an Exclusive line raises cpu_ready_o in the same cycle without requesting the bus, and the line becomes Modified.
- R5: A read that hits in Modified, Exclusive or Shared, and a write that hits in Modified, raise cpu_ready_o in the request cycle, request no bus, and leave the state unchanged.
- R6: A snooped read (snoop op 1) that hits a valid line raises snp_shared_o. On a Modified line it also raises snp_flush_o. On an Exclusive line it also raises snp_supply_o. In both cases the line becomes Shared.
- R7: A snooped read-exclusive (snoop op 2) invalidates a valid matching line. It raises snp_flush_o only if the line was Modified, and it never raises snp_shared_o or snp_supply_o.
- R8: A snoop to an Invalid line, to a line whose stored tag differs, or with op 0 or 3 produces no snoop output and no state change.
- R9: bus_req_o, bus_op_o and bus_addr_o hold steady until bus_gnt_i is seen. bus_req_o then drops, and cpu_ready_o rises only in the cycle bus_done_i arrives for the final transfer.
- R10: A miss whose index holds a Modified line of another tag first issues bus op 3 (write-back) with the victim's line address. The fill for the requested line follows.
- R11: The line address is {tag, index}, with the index in the low IDX_W bits. Bus op 0 means no transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Processor request valid, held until cpu_ready_o |
| cpu_we_i | input | 1 | 1 for a write, 0 for a read |
| cpu_line_i | input | TAG_W+IDX_W | Line address of the request |
| cpu_ready_o | output | 1 | One-cycle completion of the processor request |
| bus_req_o | output | 1 | Bus request |
| bus_op_o | output | 2 | Transaction code: 0 none, 1 read, 2 read-exclusive, 3 write-back |
| bus_addr_o | output | TAG_W+IDX_W | Line address of the transaction |
| bus_gnt_i | input | 1 | Bus grant |
| bus_done_i | input | 1 | Transfer of the granted transaction completed |
| bus_shared_i | input | 1 | Another cache holds the line, sampled with bus_done_i |
| snp_valid_i | input | 1 | Snooped transaction valid |
| snp_op_i | input | 2 | Snooped code: 1 read, 2 read-exclusive, others ignored |
| snp_line_i | input | TAG_W+IDX_W | Line address of the snooped transaction |
| snp_shared_o | output | 1 | This cache holds the snooped line |
| snp_flush_o | output | 1 | Dirty data of the snooped line is flushed |
| snp_supply_o | output | 1 | Clean exclusive data is supplied to the requester |

## Verification
Every index of the table goes through one fixed script that visits each state and takes each exit from it. Reads that miss are completed once with the shared-sense high and once with it low. Each result is then told apart through a later write and a later snoop: a write from Shared needs the bus, a write from Exclusive does not, and a snooped read of an Exclusive line returns supply. Snoops with a different tag and snoops with unused codes are sent to valid lines, and a following access shows the state did not move. Conflict misses over a dirty victim and over a clean victim separate the write-back path from the plain fill. The grant and completion delays vary across the run, which exposes outputs that do not hold while waiting or a completion raised at the wrong moment.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3} mesi_e;
  typedef enum logic [1:0] {OP_NONE = 2'd0, OP_RD = 2'd1, OP_RDX = 2'd2, OP_WB = 2'd3} bus_op_e;
  typedef enum logic [1:0] {F_IDLE = 2'd0, F_ARB = 2'd1, F_XFER = 2'd2} fsm_e;
endpackage

// File: rtl/mesi_line_table.sv
module mesi_line_table
  import mesi_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int TAG_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] cpu_idx_i,
  output mesi_e            cpu_st_o,
  output logic [TAG_W-1:0] cpu_tag_o,
  input  logic [IDX_W-1:0] snp_idx_i,
  output mesi_e            snp_st_o,
  output logic [TAG_W-1:0] snp_tag_o,
  input  logic             fill_we_i,
  input  logic [IDX_W-1:0] fill_idx_i,
  input  logic [TAG_W-1:0] fill_tag_i,
  input  mesi_e            fill_st_i,
  input  logic             snp_we_i,
  input  mesi_e            snp_st_i
);
  localparam int LINES = 1 << IDX_W;

  mesi_e            st_q  [LINES];
  logic [TAG_W-1:0] tag_q [LINES];

  // own completion wins over a snoop on the same index
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LINES; i++) begin
        st_q[i]  <= ST_I;
        tag_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (fill_we_i && fill_idx_i == IDX_W'(i)) begin
          st_q[i]  <= fill_st_i;
          tag_q[i] <= fill_tag_i;
        end else if (snp_we_i && snp_idx_i == IDX_W'(i)) begin
          st_q[i]  <= snp_st_i;
        end
      end
    end
  end

  assign cpu_st_o  = st_q[cpu_idx_i];
  assign cpu_tag_o = tag_q[cpu_idx_i];
  assign snp_st_o  = st_q[snp_idx_i];
  assign snp_tag_o = tag_q[snp_idx_i];
endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
  import mesi_pkg::*;
#(
  parameter int TAG_W = 5
) (
  input  logic             valid_i,
  input  logic [1:0]       op_i,
  input  logic [TAG_W-1:0] tag_i,
  input  mesi_e            line_st_i,
  input  logic [TAG_W-1:0] line_tag_i,
  output logic             shared_o,
  output logic             flush_o,
  output logic             supply_o,
  output logic             st_we_o,
  output mesi_e            st_nxt_o
);
  logic hit;
  assign hit = valid_i && (line_st_i != ST_I) && (line_tag_i == tag_i);

  always_comb begin
    shared_o = 1'b0;
    flush_o  = 1'b0;
    supply_o = 1'b0;
    st_we_o  = 1'b0;
    st_nxt_o = line_st_i;
    if (hit) begin
      unique case (op_i)
        OP_RD: begin
          shared_o = 1'b1;
          flush_o  = (line_st_i == ST_M);
          supply_o = (line_st_i == ST_E);
          st_we_o  = (line_st_i != ST_S);
          st_nxt_o = ST_S;
        end
        OP_RDX: begin
          flush_o  = (line_st_i == ST_M);
          st_we_o  = 1'b1;
          st_nxt_o = ST_I;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mesi_cpu_decide.sv
module mesi_cpu_decide
  import mesi_pkg::*;
#(
  parameter int TAG_W = 5
) (
  input  logic             we_i,
  input  logic [TAG_W-1:0] tag_i,
  input  mesi_e            line_st_i,
  input  logic [TAG_W-1:0] line_tag_i,
  output logic             local_o,
  output logic             upd_m_o,
  output logic             need_wb_o,
  output bus_op_e          op_o
);
  logic hit;
  assign hit = (line_st_i != ST_I) && (line_tag_i == tag_i);

  always_comb begin
    local_o   = 1'b0;
    upd_m_o   = 1'b0;
    need_wb_o = 1'b0;
    op_o      = we_i ? OP_RDX : OP_RD;
    if (hit) begin
      if (!we_i || line_st_i == ST_M) begin
        local_o = 1'b1;
      end else if (line_st_i == ST_E) begin
        local_o = 1'b1;
        upd_m_o = 1'b1;
      end
    end else begin
      need_wb_o = (line_st_i == ST_M);
    end
  end
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int TAG_W = 5
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cpu_req_i,
  input  logic                   cpu_we_i,
  input  logic [TAG_W+IDX_W-1:0] cpu_line_i,
  output logic                   cpu_ready_o,
  output logic                   bus_req_o,
  output logic [1:0]             bus_op_o,
  output logic [TAG_W+IDX_W-1:0] bus_addr_o,
  input  logic                   bus_gnt_i,
  input  logic                   bus_done_i,
  input  logic                   bus_shared_i,
  input  logic                   snp_valid_i,
  input  logic [1:0]             snp_op_i,
  input  logic [TAG_W+IDX_W-1:0] snp_line_i,
  output logic                   snp_shared_o,
  output logic                   snp_flush_o,
  output logic                   snp_supply_o
);
  localparam int LINE_W = TAG_W + IDX_W;

  logic [IDX_W-1:0] cpu_idx, snp_idx, fill_idx;
  logic [TAG_W-1:0] cpu_tag, snp_tag, fill_tag;
  mesi_e            cpu_line_st, snp_line_st, fill_st, snp_st_nxt;
  logic [TAG_W-1:0] cpu_line_tag, snp_line_tag;
  logic             fill_we, snp_we;
  logic             dec_local, dec_upd_m, dec_wb;
  bus_op_e          dec_op;

  fsm_e              fsm_q, fsm_d;
  bus_op_e           op_q, op_d, fop_q, fop_d;
  logic [LINE_W-1:0] addr_q, addr_d, rq_q, rq_d;

  assign cpu_idx = cpu_line_i[IDX_W-1:0];
  assign cpu_tag = cpu_line_i[LINE_W-1:IDX_W];
  assign snp_idx = snp_line_i[IDX_W-1:0];
  assign snp_tag = snp_line_i[LINE_W-1:IDX_W];

  mesi_line_table #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cpu_idx_i  (cpu_idx),
    .cpu_st_o   (cpu_line_st),
    .cpu_tag_o  (cpu_line_tag),
    .snp_idx_i  (snp_idx),
    .snp_st_o   (snp_line_st),
    .snp_tag_o  (snp_line_tag),
    .fill_we_i  (fill_we),
    .fill_idx_i (fill_idx),
    .fill_tag_i (fill_tag),
    .fill_st_i  (fill_st),
    .snp_we_i   (snp_we),
    .snp_st_i   (snp_st_nxt)
  );

  mesi_snoop_unit #(.TAG_W(TAG_W)) u_snoop (
    .valid_i    (snp_valid_i),
    .op_i       (snp_op_i),
    .tag_i      (snp_tag),
    .line_st_i  (snp_line_st),
    .line_tag_i (snp_line_tag),
    .shared_o   (snp_shared_o),
    .flush_o    (snp_flush_o),
    .supply_o   (snp_supply_o),
    .st_we_o    (snp_we),
    .st_nxt_o   (snp_st_nxt)
  );

  mesi_cpu_decide #(.TAG_W(TAG_W)) u_decide (
    .we_i       (cpu_we_i),
    .tag_i      (cpu_tag),
    .line_st_i  (cpu_line_st),
    .line_tag_i (cpu_line_tag),
    .local_o    (dec_local),
    .upd_m_o    (dec_upd_m),
    .need_wb_o  (dec_wb),
    .op_o       (dec_op)
  );

  always_comb begin
    fsm_d       = fsm_q;
    op_d        = op_q;
    fop_d       = fop_q;
    addr_d      = addr_q;
    rq_d        = rq_q;
    cpu_ready_o = 1'b0;
    fill_we     = 1'b0;
    fill_idx    = cpu_idx;
    fill_tag    = cpu_tag;
    fill_st     = ST_M;
    unique case (fsm_q)
      F_IDLE: begin
        if (cpu_req_i) begin
          if (dec_local) begin
            cpu_ready_o = 1'b1;
            fill_we     = dec_upd_m;
          end else begin
            rq_d  = cpu_line_i;
            fop_d = dec_op;
            fsm_d = F_ARB;
            if (dec_wb) begin
              op_d   = OP_WB;
              addr_d = {cpu_line_tag, cpu_idx};
            end else begin
              op_d   = dec_op;
              addr_d = cpu_line_i;
            end
          end
        end
      end
      F_ARB: begin
        if (bus_gnt_i) fsm_d = F_XFER;
      end
      F_XFER: begin
        if (bus_done_i) begin
          fill_we  = 1'b1;
          fill_idx = rq_q[IDX_W-1:0];
          fill_tag = rq_q[LINE_W-1:IDX_W];
          if (op_q == OP_WB) begin
            fill_st = ST_I;
            op_d    = fop_q;
            addr_d  = rq_q;
            fsm_d   = F_ARB;
          end else begin
            fill_st     = (op_q == OP_RDX) ? ST_M : (bus_shared_i ? ST_S : ST_E);
            cpu_ready_o = 1'b1;
            fsm_d       = F_IDLE;
          end
        end
      end
      default: fsm_d = F_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsm_q  <= F_IDLE;
      op_q   <= OP_NONE;
      fop_q  <= OP_NONE;
      addr_q <= '0;
      rq_q   <= '0;
    end else begin
      fsm_q  <= fsm_d;
      op_q   <= op_d;
      fop_q  <= fop_d;
      addr_q <= addr_d;
      rq_q   <= rq_d;
    end
  end

  assign bus_req_o  = (fsm_q == F_ARB);
  assign bus_op_o   = (fsm_q == F_ARB) ? op_q : OP_NONE;
  assign bus_addr_o = addr_q;
endmodule

// File: rtl/mesi_line_ctrl_chk.sv
module mesi_line_ctrl_chk
  import mesi_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int TAG_W = 5
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   cpu_ready_o,
  input logic                   bus_req_o,
  input logic [1:0]             bus_op_o,
  input logic [TAG_W+IDX_W-1:0] bus_addr_o,
  input logic                   bus_gnt_i,
  input logic                   snp_valid_i,
  input logic [1:0]             snp_op_i,
  input logic [TAG_W+IDX_W-1:0] snp_line_i,
  input logic                   snp_shared_o,
  input logic                   snp_flush_o,
  input logic                   snp_supply_o,
  input logic                   fill_we
);
  // request held with stable op and address until granted
  p_req_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_gnt_i |=> bus_req_o && $stable(bus_op_o) && $stable(bus_addr_o));

  p_req_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_gnt_i |=> !bus_req_o);

  p_ready_no_req_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ready_o |-> !bus_req_o);

  p_req_has_op_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> bus_op_o != OP_NONE);

  p_supply_on_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_supply_o |-> snp_valid_i && snp_op_i == OP_RD && snp_shared_o && !snp_flush_o);

  p_rdx_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_valid_i && snp_op_i == OP_RDX |-> !snp_shared_o && !snp_supply_o);

  p_unused_op_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snp_valid_i || snp_op_i == OP_NONE || snp_op_i == OP_WB
      |-> !snp_shared_o && !snp_flush_o && !snp_supply_o);

  // after a flushing read the line is Shared: a repeat read must not flush
  p_flush_once_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_flush_o && snp_op_i == OP_RD && !fill_we |=>
      (snp_valid_i && snp_op_i == OP_RD && snp_line_i == $past(snp_line_i) && !fill_we)
        |-> !snp_flush_o && snp_shared_o);
endmodule

bind mesi_line_ctrl mesi_line_ctrl_chk #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cpu_ready_o  (cpu_ready_o),
  .bus_req_o    (bus_req_o),
  .bus_op_o     (bus_op_o),
  .bus_addr_o   (bus_addr_o),
  .bus_gnt_i    (bus_gnt_i),
  .snp_valid_i  (snp_valid_i),
  .snp_op_i     (snp_op_i),
  .snp_line_i   (snp_line_i),
  .snp_shared_o (snp_shared_o),
  .snp_flush_o  (snp_flush_o),
  .snp_supply_o (snp_supply_o),
  .fill_we      (fill_we)
);

// File: tb/sim_mesi_line_ctrl.sv
`timescale 1ns/1ps
module sim_mesi_line_ctrl;
  localparam int IDX_W = 3;
  localparam int TAG_W = 5;
  localparam int LW    = IDX_W + TAG_W;
  localparam int LINES = 1 << IDX_W;
  localparam logic [1:0] SI = 2'd0, SS = 2'd1, SE = 2'd2, SM = 2'd3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_req = 1'b0, cpu_we = 1'b0;
  logic [LW-1:0] cpu_line = '0;
  logic          cpu_ready;
  logic          bus_req;
  logic [1:0]    bus_op;
  logic [LW-1:0] bus_addr;
  logic          bus_gnt = 1'b0, bus_done = 1'b0, bus_shared = 1'b0;
  logic          snp_valid = 1'b0;
  logic [1:0]    snp_op = 2'd0;
  logic [LW-1:0] snp_line = '0;
  logic          snp_shared, snp_flush, snp_supply;

  int n_chk = 0, n_fail = 0, seq = 0;
  bit finished = 0;
  logic [1:0]       m_st  [LINES];
  logic [TAG_W-1:0] m_tag [LINES];

  always #2 clk = ~clk;

  mesi_line_ctrl #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_line_i(cpu_line), .cpu_ready_o(cpu_ready),
    .bus_req_o(bus_req), .bus_op_o(bus_op), .bus_addr_o(bus_addr),
    .bus_gnt_i(bus_gnt), .bus_done_i(bus_done), .bus_shared_i(bus_shared),
    .snp_valid_i(snp_valid), .snp_op_i(snp_op), .snp_line_i(snp_line),
    .snp_shared_o(snp_shared), .snp_flush_o(snp_flush), .snp_supply_o(snp_supply)
  );

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // one bus transaction: wait for request, grant after d cycles, complete after w
  task automatic bus_step(input logic [1:0] op, input logic [LW-1:0] addr, input logic sh,
                          input logic last, input string rq);
    int d, w;
    d = seq % 3;
    w = (seq / 3) % 2;
    seq++;
    @(posedge clk); @(negedge clk); bus_done = 1'b0; #1;
    chk(rq, "bus_req", bus_req, 1);
    chk(rq, "bus_op", bus_op, op);
    chk(rq, "bus_addr", bus_addr, addr);
    for (int k = 0; k < d; k++) begin
      @(posedge clk); @(negedge clk); #1;
      chk("R9", "bus_req held", bus_req, 1);
      chk("R9", "bus_op held", bus_op, op);
    end
    bus_gnt = 1'b1;
    @(posedge clk); @(negedge clk); bus_gnt = 1'b0; #1;
    chk("R9", "bus_req after grant", bus_req, 0);
    chk("R9", "ready before done", cpu_ready, 0);
    for (int k = 0; k < w; k++) begin
      @(posedge clk); @(negedge clk); #1;
      chk("R9", "ready waiting done", cpu_ready, 0);
    end
    bus_done = 1'b1; bus_shared = sh; #1;
    chk(rq, "ready at done", cpu_ready, last);
  endtask

  task automatic cpu_op(input logic we, input logic [TAG_W-1:0] tg, input logic [IDX_W-1:0] ix,
                        input logic sh, input string rq);
    logic hit, lcl;
    hit = (m_st[ix] != SI) && (m_tag[ix] == tg);
    lcl = hit && !(we && m_st[ix] == SS);
    @(negedge clk); cpu_req = 1'b1; cpu_we = we; cpu_line = {tg, ix}; #1;
    if (lcl) begin
      chk(rq, "local ready", cpu_ready, 1);
      chk(rq, "local no bus", bus_req, 0);
      if (we) m_st[ix] = SM;
    end else begin
      chk(rq, "ready on miss", cpu_ready, 0);
      if (!hit && m_st[ix] == SM) begin
        bus_step(2'd3, {m_tag[ix], ix}, 1'b0, 1'b0, "R10");
        m_st[ix] = SI;
      end
      bus_step(we ? 2'd2 : 2'd1, {tg, ix}, sh, 1'b1, rq);
      m_st[ix]  = we ? SM : (sh ? SS : SE);
      m_tag[ix] = tg;
    end
    @(posedge clk); @(negedge clk); bus_done = 1'b0; bus_shared = 1'b0; cpu_req = 1'b0;
  endtask

  task automatic snoop(input logic [1:0] op, input logic [TAG_W-1:0] tg, input logic [IDX_W-1:0] ix,
                       input string rq);
    logic hit;
    hit = (m_st[ix] != SI) && (m_tag[ix] == tg) && (op == 2'd1 || op == 2'd2);
    @(negedge clk); snp_valid = 1'b1; snp_op = op; snp_line = {tg, ix}; #1;
    chk(rq, "snp_flush", snp_flush, hit && m_st[ix] == SM);
    chk(rq, "snp_supply", snp_supply, hit && op == 2'd1 && m_st[ix] == SE);
    chk(rq, "snp_shared", snp_shared, hit && op == 2'd1);
    @(posedge clk);
    if (hit) m_st[ix] = (op == 2'd1) ? SS : SI;
    @(negedge clk); snp_valid = 1'b0; snp_op = 2'd0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < LINES; i++) begin m_st[i] = SI; m_tag[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1", "bus_req after reset", bus_req, 0);
    chk("R1", "ready after reset", cpu_ready, 0);
    for (int i = 0; i < LINES; i++) begin
      logic [IDX_W-1:0] ix;
      logic [TAG_W-1:0] t0, t1;
      ix = IDX_W'(i);
      t0 = TAG_W'(i + 1);
      t1 = TAG_W'(i + 9);
      snoop(2'd1, t0, ix, "R1");
      snoop(2'd2, '0, ix, "R8");
      cpu_op(1'b0, t0, ix, 1'b0, "R2");     // -> E
      snoop(2'd3, t0, ix, "R8");
      snoop(2'd0, t0, ix, "R8");
      snoop(2'd1, t1, ix, "R8");
      snoop(2'd1, t0, ix, "R6");           // E -> S, supply
      cpu_op(1'b0, t0, ix, 1'b0, "R5");
      cpu_op(1'b1, t0, ix, 1'b0, "R3");     // S -> M
      cpu_op(1'b1, t0, ix, 1'b0, "R5");
      cpu_op(1'b0, t0, ix, 1'b0, "R5");
      snoop(2'd1, t0, ix, "R6");           // M -> S, flush
      snoop(2'd2, t0, ix, "R7");           // S -> I
      cpu_op(1'b0, t0, ix, 1'b1, "R2");     // -> S
      cpu_op(1'b1, t0, ix, 1'b0, "R3");     // S -> M
      cpu_op(1'b0, t1, ix, 1'b0, "R10");    // write-back then fill E
      snoop(2'd1, t0, ix, "R8");
      cpu_op(1'b1, t1, ix, 1'b0, "R4");     // E -> M local
      snoop(2'd2, t1, ix, "R7");           // M -> I, flush
      cpu_op(1'b1, t1, ix, 1'b0, "R3");     // I -> M
      cpu_op(1'b0, t0, ix, 1'b1, "R10");    // write-back then fill S
      cpu_op(1'b0, t1, ix, 1'b0, "R2");     // clean victim, plain fill E
      snoop(2'd3, t1, ix, "R8");
      cpu_op(1'b1, t1, ix, 1'b0, "R4");     // still E: no bus
      snoop(2'd2, t1, ix, "R7");
    end
    finish_run();
  end
endmodule